// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

This block collects pin changes from three 8-pin GPIO ports plus three internal signals and turns them into per-line interrupt requests and a single event pulse. Software configures it through a small 32-bit register bus. Each GPIO line 0 to 7 picks its pin from one of the ports through a source-select field. Each implemented line then has an interrupt enable, an event enable, a rising-edge select, a falling-edge select and a software trigger. A pending register latches detected triggers until software clears them by writing ones.

GPIO pins go through a two-flop synchronizer before edge detection. The internal sources on lines 17 and 18 are already in the clock domain and are edge-detected directly. Line 29 is a level source: it is not latched, and it is gated only by its interrupt and event enables.

The register bus is a single-cycle write port (`wr_en`, `addr`, `wdata`) and a combinational read port: `rdata` always shows the register selected by `addr`.

Top module: `extint_ctrl`

## Requirements
- R1: The implemented lines are 0–7, 17, 18 and 29. In every per-line register, bit n belongs to line n. Every other bit reads 0 and ignores writes. The rising select, falling select, software trigger and latched pending bits exist only for lines 0–7, 17 and 18 (mask 0x000600FF). The two enable registers also carry line 29 (mask 0x200600FF).
- R2: After reset the interrupt enable reads 0x20060000, so lines 17, 18 and 29 are enabled. Every other register reads 0, `irq` is 0 and `evt_pulse` is 0. With all source-select fields at 0, every GPIO line selects port A.
- R3: The word address selects a register as follows: 0 pending, 1 interrupt enable, 2 event enable, 3 rising select, 4 falling select, 5 software trigger, 6 source select for lines 0–3, 7 source select for lines 4–7. A write takes effect at the clock edge where `wr_en` is sampled high.
- R4: A rising edge on a line with its rising select set, or a falling edge on a line with its falling select set, sets that line's pending bit. With both selects set, either edge sets it. A GPIO pin change made before clock edge E0 shows in the pending bit after edge E2. A change on internal lines 17 or 18 shows after the next edge.
- R5: An edge that is detected in the same cycle as a write to the rising-select register is dropped if it is rising. An edge detected in the same cycle as a write to the falling-select register is dropped if it is falling. An edge of the other polarity is not dropped by that write.
- R6: The pending register is write-1-to-clear: each 1 clears that line's bit, and each 0 leaves it unchanged. If a trigger and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Writing 1 to a software-trigger bit that reads 0 sets that bit. It also sets the matching pending bit if that line's interrupt enable is 1. Writing 1 to a bit that already reads 1 does nothing. A software-trigger bit stays 1 until the matching pending bit is cleared, and that clear also clears it.
- R8: Line 29 has no select or software-trigger bit. Pending bit 29 reads the live level of `int_src[2]`, writes to pending bit 29 have no effect, and `irq[29]` is that level ANDed with interrupt enable bit 29.
- R9: Line k takes its source-select field from register 6 (k < 4) or register 7 (k ≥ 4), at bit offset 8·(k mod 4). Port A is 0, port B is 1 and port C is 2, and line k uses pin k of the chosen port. The fields for lines 0–4 are 2 bits wide; code 3 selects no pin, and the line stays low. The fields for lines 5–7 are 1 bit wide (A or B only). The unused field bits read 0, so register 6 masks to 0x03030303 and register 7 to 0x01010103.
- R10: For the latched lines, `irq[n]` equals pending bit n ANDed with interrupt enable bit n. Clearing an enable hides the request without clearing the pending bit.
- R11: `evt_pulse` is high for exactly one cycle after a trigger on a line whose event enable is 1. A trigger here is a selected hardware edge, a software-trigger set, or a rising edge of line 29. The pulse does not depend on the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |
| pa_pin | input | 8 | Port A pins |
| pb_pin | input | 8 | Port B pins |
| pc_pin | input | 8 | Port C pins |
| int_src | input | 3 | Internal sources: bit 0 line 17, bit 1 line 18, bit 2 line 29 |
| irq | output | 32 | Per-line interrupt requests |
| evt_pulse | output | 1 | One-cycle event pulse |

## Verification
A wrong source-select decode or a wrong field mask sets a pending bit on the wrong line, or no pending bit at all. That shows in the pending read and in `irq` three edges after the pin change. A lost edge-drop condition, or a wrong pending set/clear priority, leaves a pending bit with the wrong value one edge after the write in question. A stuck software-trigger bit shows as a software write that fails to set pending, or as a readback that stays 1 after the clear. Event-path faults show as a pulse count other than one in the few cycles after a trigger.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int N_GPIO     = 8;
    localparam int N_PORT     = 3;
    localparam int SEL_W      = 2;
    localparam int N_INT      = 3;
    localparam int FIELD_STEP = 8;
    localparam int FIELDS_PER_REG = DATA_W / FIELD_STEP;
    localparam int EDGE_LINE0 = 17;
    localparam int EDGE_LINE1 = 18;
    localparam int LVL_LINE   = 29;

    localparam logic [DATA_W-1:0] LATCH_MASK  = 32'h0006_00FF;
    localparam logic [DATA_W-1:0] ALL_MASK    = 32'h2006_00FF;
    localparam logic [DATA_W-1:0] INT_EN_RST  = 32'h2006_0000;
    localparam logic [DATA_W-1:0] SRC_LO_MASK = 32'h0303_0303;
    localparam logic [DATA_W-1:0] SRC_HI_MASK = 32'h0101_0103;

    typedef enum logic [ADDR_W-1:0] {
        REG_PEND   = 3'd0,
        REG_INT_EN = 3'd1,
        REG_EVT_EN = 3'd2,
        REG_RISE   = 3'd3,
        REG_FALL   = 3'd4,
        REG_SWTRG  = 3'd5,
        REG_SRC_LO = 3'd6,
        REG_SRC_HI = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/extint_frontend.sv
module extint_frontend
    import extint_pkg::*;
#(
    parameter int LINES = N_GPIO,
    parameter int PORTS = N_PORT,
    parameter int SW    = SEL_W,
    parameter int NINT  = N_INT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS*LINES-1:0] pins,
    input  logic [LINES*SW-1:0]    sel,
    input  logic [NINT-1:0]        int_src,
    output logic [LINES-1:0]       gpio_rise,
    output logic [LINES-1:0]       gpio_fall,
    output logic [NINT-1:0]        int_rise,
    output logic [NINT-2:0]        int_fall
);
    localparam int SYNC_D = 3;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [SW-1:0]     sel_k;
        logic              raw;
        logic [SYNC_D-1:0] sh;

        assign sel_k = sel[k*SW +: SW];

        // pick pin k of the selected port; an unused code yields a quiet line
        always_comb begin
            raw = 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                if (sel_k == SW'(p)) raw = pins[p*LINES + k];
            end
        end

        // two synchronizer stages plus one history stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_D-2:0], raw};
        end

        assign gpio_rise[k] =  sh[SYNC_D-2] & ~sh[SYNC_D-1];
        assign gpio_fall[k] = ~sh[SYNC_D-2] &  sh[SYNC_D-1];
    end

    logic [NINT-1:0] int_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_prev <= '0;
        else        int_prev <= int_src;
    end

    assign int_rise = int_src & ~int_prev;
    assign int_fall = ~int_src[NINT-2:0] & int_prev[NINT-2:0];
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rise_ev,
    input  logic [DATA_W-1:0] fall_ev,
    input  logic              lvl_src,
    input  logic              lvl_rise,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] irq,
    output logic              evt_pulse,
    output logic [DATA_W-1:0] src_lo_q,
    output logic [DATA_W-1:0] src_hi_q,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] sw_q,
    output logic [DATA_W-1:0] set_vec
);
    logic [DATA_W-1:0] int_en_q, evt_en_q, rise_q, fall_q;
    logic [DATA_W-1:0] hw_trig, sw_new, clr_vec, lvl_vec, lvl_edge_vec;
    logic [DATA_W-1:0] pend_d, sw_d;
    logic              w_rise, w_fall, w_sw, w_pend, evt_d;

    assign w_rise = wr_en && (reg_sel_e'(addr) == REG_RISE);
    assign w_fall = wr_en && (reg_sel_e'(addr) == REG_FALL);
    assign w_sw   = wr_en && (reg_sel_e'(addr) == REG_SWTRG);
    assign w_pend = wr_en && (reg_sel_e'(addr) == REG_PEND);

    assign lvl_vec      = DATA_W'(lvl_src)  << LVL_LINE;
    assign lvl_edge_vec = DATA_W'(lvl_rise) << LVL_LINE;

    // next-state of pending, software trigger and event pulse
    always_comb begin
        hw_trig = (rise_ev & rise_q & {DATA_W{~w_rise}})
                | (fall_ev & fall_q & {DATA_W{~w_fall}});
        sw_new  = (w_sw ? wdata : '0) & LATCH_MASK & ~sw_q;
        set_vec = hw_trig | (sw_new & int_en_q);
        clr_vec = (w_pend ? wdata : '0) & LATCH_MASK;
        pend_d  = (pend_q & ~clr_vec) | set_vec;
        sw_d    = (sw_q | sw_new) & ~clr_vec;
        evt_d   = |((hw_trig | sw_new | lvl_edge_vec) & evt_en_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en_q  <= INT_EN_RST;
            evt_en_q  <= '0;
            rise_q    <= '0;
            fall_q    <= '0;
            src_lo_q  <= '0;
            src_hi_q  <= '0;
            pend_q    <= '0;
            sw_q      <= '0;
            evt_pulse <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (reg_sel_e'(addr))
                    REG_INT_EN: int_en_q <= wdata & ALL_MASK;
                    REG_EVT_EN: evt_en_q <= wdata & ALL_MASK;
                    REG_RISE:   rise_q   <= wdata & LATCH_MASK;
                    REG_FALL:   fall_q   <= wdata & LATCH_MASK;
                    REG_SRC_LO: src_lo_q <= wdata & SRC_LO_MASK;
                    REG_SRC_HI: src_hi_q <= wdata & SRC_HI_MASK;
                    default: ;
                endcase
            end
            pend_q    <= pend_d;
            sw_q      <= sw_d;
            evt_pulse <= evt_d;
        end
    end

    // outputs
    always_comb begin
        irq = (pend_q | lvl_vec) & int_en_q;
        unique case (reg_sel_e'(addr))
            REG_PEND:   rdata = pend_q | lvl_vec;
            REG_INT_EN: rdata = int_en_q;
            REG_EVT_EN: rdata = evt_en_q;
            REG_RISE:   rdata = rise_q;
            REG_FALL:   rdata = fall_q;
            REG_SWTRG:  rdata = sw_q;
            REG_SRC_LO: rdata = src_lo_q;
            REG_SRC_HI: rdata = src_hi_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_GPIO-1:0] pa_pin,
    input  logic [N_GPIO-1:0] pb_pin,
    input  logic [N_GPIO-1:0] pc_pin,
    input  logic [N_INT-1:0]  int_src,
    output logic [DATA_W-1:0] irq,
    output logic              evt_pulse
);
    logic [N_GPIO*SEL_W-1:0] sel_flat;
    logic [N_GPIO-1:0]       gpio_rise, gpio_fall;
    logic [N_INT-1:0]        int_rise;
    logic [N_INT-2:0]        int_fall;
    logic [DATA_W-1:0]       rise_vec, fall_vec;
    logic [DATA_W-1:0]       src_lo_q, src_hi_q, pend_q, sw_q, set_vec;

    // select fields: one per byte, lower register for the first four lines
    for (genvar k = 0; k < N_GPIO; k++) begin : g_sel
        if (k < FIELDS_PER_REG) begin : g_lo
            assign sel_flat[k*SEL_W +: SEL_W] = src_lo_q[k*FIELD_STEP +: SEL_W];
        end else begin : g_hi
            assign sel_flat[k*SEL_W +: SEL_W] =
                src_hi_q[(k-FIELDS_PER_REG)*FIELD_STEP +: SEL_W];
        end
    end

    extint_frontend u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      ({pc_pin, pb_pin, pa_pin}),
        .sel       (sel_flat),
        .int_src   (int_src),
        .gpio_rise (gpio_rise),
        .gpio_fall (gpio_fall),
        .int_rise  (int_rise),
        .int_fall  (int_fall)
    );

    assign rise_vec = DATA_W'(gpio_rise)
                    | (DATA_W'(int_rise[0]) << EDGE_LINE0)
                    | (DATA_W'(int_rise[1]) << EDGE_LINE1);
    assign fall_vec = DATA_W'(gpio_fall)
                    | (DATA_W'(int_fall[0]) << EDGE_LINE0)
                    | (DATA_W'(int_fall[1]) << EDGE_LINE1);

    extint_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rise_ev   (rise_vec),
        .fall_ev   (fall_vec),
        .lvl_src   (int_src[N_INT-1]),
        .lvl_rise  (int_rise[N_INT-1]),
        .rdata     (rdata),
        .irq       (irq),
        .evt_pulse (evt_pulse),
        .src_lo_q  (src_lo_q),
        .src_hi_q  (src_hi_q),
        .pend_q    (pend_q),
        .sw_q      (sw_q),
        .set_vec   (set_vec)
    );
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
    import extint_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] irq,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] sw_q,
    input logic [DATA_W-1:0] set_vec,
    input logic [DATA_W-1:0] fall_ev
);
    // R1
    unimpl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ALL_MASK) == '0);

    // R1
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr <= ADDR_W'(REG_SWTRG)) |-> ((rdata & ~ALL_MASK) == '0));

    // R9
    src_lo_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(REG_SRC_LO)) |-> ((rdata & ~SRC_LO_MASK) == '0));

    // R9
    src_hi_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(REG_SRC_HI)) |-> ((rdata & ~SRC_HI_MASK) == '0));

    // R5
    drop_on_rise_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_RISE) && fall_ev == '0) |=> (pend_q == $past(pend_q)));

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_PEND) && set_vec == '0)
        |=> ((pend_q & $past(wdata & LATCH_MASK)) == '0));

    // R7
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_PEND))
        |=> ((sw_q & $past(wdata & LATCH_MASK)) == '0));
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .pend_q  (pend_q),
    .sw_q    (sw_q),
    .set_vec (set_vec),
    .fall_ev (fall_vec)
);

// File: tb/extint_ctrl_bench.sv
`timescale 1ns/1ps
module extint_ctrl_bench;
    import extint_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  pa = '0, pb = '0, pc = '0;
    logic [2:0]  isrc = '0;
    logic [31:0] rdata, irq;
    logic        evt;
    int          n_chk = 0, n_fail = 0, evt_cnt = 0;
    bit          done = 1'b0;

    extint_ctrl u_extint_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pa_pin(pa), .pb_pin(pb), .pc_pin(pc), .int_src(isrc),
        .irq(irq), .evt_pulse(evt)
    );

    always #5 clk = ~clk;
    always @(negedge clk) if (evt) evt_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int p, input int k, input logic v);
        case (p)
            0: pa[k] = v;
            1: pb[k] = v;
            default: pc[k] = v;
        endcase
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        logic [31:0] v;
        int c0;
        idle(3); rst_n = 1'b1; idle(1);

        // R2 reset state
        rd(REG_PEND, v);   chk("R2 pend", v, 32'h0);
        rd(REG_INT_EN, v); chk("R2 int_en", v, 32'h2006_0000);
        rd(REG_EVT_EN, v); chk("R2 evt_en", v, 32'h0);
        rd(REG_RISE, v);   chk("R2 rise", v, 32'h0);
        rd(REG_FALL, v);   chk("R2 fall", v, 32'h0);
        rd(REG_SWTRG, v);  chk("R2 swtrg", v, 32'h0);
        rd(REG_SRC_LO, v); chk("R2 src_lo", v, 32'h0);
        rd(REG_SRC_HI, v); chk("R2 src_hi", v, 32'h0);
        chk("R2 irq", irq, 32'h0);
        chk("R2 evt", {31'b0, evt}, 32'h0);

        // R1 / R3 masks on write
        wr(REG_INT_EN, '1); rd(REG_INT_EN, v); chk("R1 int_en mask", v, 32'h2006_00FF);
        wr(REG_EVT_EN, '1); rd(REG_EVT_EN, v); chk("R1 evt_en mask", v, 32'h2006_00FF);
        wr(REG_EVT_EN, '0);
        wr(REG_RISE, '1);   rd(REG_RISE, v);   chk("R1 rise mask", v, 32'h0006_00FF);
        wr(REG_FALL, '1);   rd(REG_FALL, v);   chk("R1 fall mask", v, 32'h0006_00FF);
        wr(REG_RISE, '0);   wr(REG_FALL, '0);
        wr(REG_SWTRG, '1);
        rd(REG_PEND, v);  chk("R7 sw all pend", v, 32'h0006_00FF);
        rd(REG_SWTRG, v); chk("R1 sw mask", v, 32'h0006_00FF);
        chk("R10 irq all", irq, 32'h0006_00FF);
        wr(REG_PEND, '1);
        rd(REG_PEND, v);  chk("R6 pend clear all", v, 32'h0);
        rd(REG_SWTRG, v); chk("R7 sw clear all", v, 32'h0);

        // R9 field masks
        wr(REG_SRC_LO, '1); rd(REG_SRC_LO, v); chk("R9 src_lo mask", v, 32'h0303_0303);
        wr(REG_SRC_HI, '1); rd(REG_SRC_HI, v); chk("R9 src_hi mask", v, 32'h0101_0103);
        wr(REG_SRC_LO, '0); wr(REG_SRC_HI, '0);

        // R9 / R4 sweep over every line and port code
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 3; p++) begin
                int eff;
                eff = (k < 5) ? p : (p & 1);
                wr(REG_RISE, 32'h1 << k);
                wr((k < 4) ? REG_SRC_LO : REG_SRC_HI, 32'(p) << ((k % 4) * 8));
                for (int q = 0; q < 3; q++) if (q != eff) set_pin(q, k, 1'b1);
                idle(4);
                rd(REG_PEND, v);
                chk($sformatf("R9 line %0d code %0d decoy", k, p), v, 32'h0);
                set_pin(eff, k, 1'b1);
                idle(4);
                rd(REG_PEND, v);
                chk($sformatf("R9 line %0d code %0d pend", k, p), v, 32'h1 << k);
                chk($sformatf("R10 line %0d irq", k), irq, 32'h1 << k);
                pa = '0; pb = '0; pc = '0;
                idle(4);
                wr(REG_PEND, '1);
                wr((k < 4) ? REG_SRC_LO : REG_SRC_HI, '0);
            end
        end

        // R9 code 3 on a wide field selects nothing
        wr(REG_RISE, 32'h1); wr(REG_SRC_LO, 32'h3);
        pa[0] = 1; pb[0] = 1; pc[0] = 1; idle(4);
        rd(REG_PEND, v); chk("R9 code3 quiet", v, 32'h0);
        pa = '0; pb = '0; pc = '0; idle(4);
        wr(REG_SRC_LO, '0); wr(REG_PEND, '1);

        // R4 edge mode sweep on line 3
        for (int m = 0; m < 4; m++) begin
            wr(REG_RISE, 32'(m & 1) << 3);
            wr(REG_FALL, 32'((m >> 1) & 1) << 3);
            pa[3] = 1; idle(4);
            rd(REG_PEND, v); chk($sformatf("R4 mode %0d rise", m), v, 32'(m & 1) << 3);
            wr(REG_PEND, '1);
            pa[3] = 0; idle(4);
            rd(REG_PEND, v); chk($sformatf("R4 mode %0d fall", m), v, 32'((m >> 1) & 1) << 3);
            wr(REG_PEND, '1);
        end

        // R4 latency through the synchronizer
        wr(REG_RISE, 32'h8); wr(REG_FALL, '0);
        pa[3] = 1; idle(2);
        rd(REG_PEND, v); chk("R4 latency early", v, 32'h0);
        idle(1);
        rd(REG_PEND, v); chk("R4 latency on time", v, 32'h8);
        pa[3] = 0; idle(4); wr(REG_PEND, '1);

        // R4 internal edge lines 17 and 18
        wr(REG_RISE, 32'h3 << 17);
        isrc[0] = 1; idle(1);
        rd(REG_PEND, v); chk("R4 line17 rise", v, 32'h1 << 17);
        isrc[1] = 1; idle(1);
        rd(REG_PEND, v); chk("R4 line18 rise", v, 32'h3 << 17);
        wr(REG_PEND, '1);
        wr(REG_FALL, 32'h3 << 17);
        isrc[1:0] = 0; idle(1);
        rd(REG_PEND, v); chk("R4 line17/18 fall", v, 32'h3 << 17);
        wr(REG_PEND, '1); wr(REG_RISE, '0); wr(REG_FALL, '0);

        // R5 edge dropped by a same-cycle select write
        wr(REG_RISE, 32'h1);
        pa[0] = 1; @(negedge clk); wr(REG_RISE, 32'h1); idle(3);
        rd(REG_PEND, v); chk("R5 rise dropped", v, 32'h0);
        wr(REG_FALL, 32'h1);
        pa[0] = 0; @(negedge clk); wr(REG_FALL, 32'h1); idle(3);
        rd(REG_PEND, v); chk("R5 fall dropped", v, 32'h0);
        pa[0] = 1; idle(4); wr(REG_PEND, '1);
        pa[0] = 0; @(negedge clk); wr(REG_RISE, 32'h1); idle(3);
        rd(REG_PEND, v); chk("R5 fall kept on rise write", v, 32'h1);

        // R6 write-1-to-clear details
        wr(REG_PEND, 32'h0); rd(REG_PEND, v); chk("R6 zero write", v, 32'h1);
        wr(REG_PEND, 32'h2); rd(REG_PEND, v); chk("R6 other bit", v, 32'h1);
        wr(REG_PEND, 32'h1); rd(REG_PEND, v); chk("R6 clear", v, 32'h0);
        wr(REG_RISE, 32'h1 << 17);
        isrc[0] = 1; idle(1); isrc[0] = 0; idle(1);
        @(negedge clk); isrc[0] = 1; wr_en = 1; addr = REG_PEND; wdata = 32'h1 << 17;
        @(negedge clk); wr_en = 0;
        rd(REG_PEND, v); chk("R6 set wins", v, 32'h1 << 17);
        isrc[0] = 0; idle(1); wr(REG_PEND, '1); wr(REG_RISE, '0);

        // R7 software trigger
        wr(REG_SWTRG, 32'h4);
        rd(REG_PEND, v);  chk("R7 sw sets pend", v, 32'h4);
        rd(REG_SWTRG, v); chk("R7 sw reads set", v, 32'h4);
        wr(REG_INT_EN, ALL_MASK & ~32'h10);
        wr(REG_SWTRG, 32'h10);
        rd(REG_PEND, v);  chk("R7 masked no pend", v, 32'h4);
        rd(REG_SWTRG, v); chk("R7 sw bit held", v, 32'h14);
        wr(REG_PEND, 32'h4);
        rd(REG_SWTRG, v); chk("R7 clear frees sw", v, 32'h10);
        wr(REG_INT_EN, '1);
        wr(REG_SWTRG, 32'h10);
        rd(REG_PEND, v);  chk("R7 already set no effect", v, 32'h0);
        wr(REG_PEND, 32'h10);
        rd(REG_SWTRG, v); chk("R7 clear via pend", v, 32'h0);

        // R8 level line 29
        isrc[2] = 1; idle(1);
        rd(REG_PEND, v); chk("R8 level read", v, 32'h1 << 29);
        chk("R8 irq", irq, 32'h1 << 29);
        wr(REG_PEND, 32'h1 << 29);
        rd(REG_PEND, v); chk("R8 clear ignored", v, 32'h1 << 29);
        wr(REG_INT_EN, '0);
        chk("R8 gated", irq, 32'h0);
        isrc[2] = 0; idle(1);
        rd(REG_PEND, v); chk("R8 level low", v, 32'h0);
        wr(REG_INT_EN, '1);

        // R10 enable hides without clearing
        wr(REG_SWTRG, 32'h20);
        chk("R10 irq on", irq, 32'h20);
        wr(REG_INT_EN, '0);
        chk("R10 irq hidden", irq, 32'h0);
        rd(REG_PEND, v); chk("R10 pend kept", v, 32'h20);
        wr(REG_INT_EN, '1);
        chk("R10 irq back", irq, 32'h20);
        wr(REG_PEND, '1);

        // R11 event pulse
        wr(REG_EVT_EN, 32'h2); wr(REG_RISE, 32'h2);
        c0 = evt_cnt; pa[1] = 1; idle(5);
        chk("R11 one pulse", 32'(evt_cnt - c0), 32'd1);
        pa[1] = 0; idle(4);
        c0 = evt_cnt; pa[1] = 1; idle(5);
        chk("R11 pulse with pend set", 32'(evt_cnt - c0), 32'd1);
        pa[1] = 0; idle(4);
        wr(REG_EVT_EN, '0);
        c0 = evt_cnt; pa[1] = 1; idle(5);
        chk("R11 disabled", 32'(evt_cnt - c0), 32'd0);
        pa[1] = 0; idle(4); wr(REG_PEND, '1);
        wr(REG_EVT_EN, 32'h40);
        c0 = evt_cnt; wr(REG_SWTRG, 32'h40); idle(2);
        chk("R11 sw event", 32'(evt_cnt - c0), 32'd1);
        wr(REG_PEND, '1);
        wr(REG_EVT_EN, 32'h1 << 29);
        c0 = evt_cnt; isrc[2] = 1; idle(3);
        chk("R11 line29 event", 32'(evt_cnt - c0), 32'd1);
        isrc[2] = 0; idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule